// File: doc/BRIEF.md
# Daisy-Chain Input Serializer Readout Controller

This block reads a chain of up to `MAX_CHIPS` industrial input serializers in one SPI burst. Each serializer carries eight digital inputs and, in status-frame mode, follows its input byte with a status byte. The status byte holds a 5-bit CRC of the input byte, an overtemperature flag and two active-low supply flags. The controller runs the SPI burst as master in mode 0 and stores the received bytes per chip. It then decides, chip by chip, whether that chip's inputs can be trusted. It also folds in the level of each chip's fault line, which can be one line per chip or a single line shared by all chips.

A single-cycle `start_i` launches a burst. The chain length, the frame mode, the ignore-undervoltage option and the fault-line wiring are captured in the cycle the request is accepted. When the burst ends, every result bitmap updates in the same cycle that `done_o` pulses. The results then hold until the next `done_o`. The block has no streaming data path. Its results are a register snapshot and its inputs are control levels, so every port is a plain level or a pulse, with no valid/ready handshake and no back-pressure.

Top module: `chain_diag_reader`

## Requirements
- R1: While `cs_n_o` is high, `sclk_o` is low. A burst holds `cs_n_o` low for exactly 8×N×W rising `sclk_o` edges, where W is 2 in status-frame mode (`mode16_i`=1) and 1 otherwise. `miso_i` is sampled on each rising edge, most significant bit of each byte first.
- R2: A `start_i` pulse that arrives while `busy_o` is high is ignored. It neither lengthens nor restarts the burst that is running, and it changes none of that burst's captured settings.
- R3: Chip i's bytes start at stream byte i×W. In status-frame mode the input byte comes first and the status byte second. `inputs_o[8i+k]` is bit k of chip i's input byte. Bits of chips at or above N read 0, and so do all flags of those chips.
- R4: In status-frame mode, `crc_err_o[i]` is set when status bits [7:3] differ from the CRC of the input byte. The CRC uses generator x^5+x^4+x^2+1, starts from zero and consumes the byte most significant bit first.
- R5: In status-frame mode, `over_temp_o[i]` equals status bit 1 (active high).
- R6: In status-frame mode with ignore-undervoltage clear, `uv_alarm_o[i]` is the inverse of status bit 2 and `uv_warn_o[i]` is the inverse of status bit 0.
- R7: When `ign_uv_i` is captured high, `uv_alarm_o`, `uv_warn_o` and `fault_o` are all zero, whatever the status bytes and fault lines show.
- R8: With `fault_shared_i`=0, `fault_o[i]` follows `fault_pin_i[i]`. With `fault_shared_i`=1, `fault_pin_i[0]` applies to every chip. The lines are sampled at the clock edge that raises `done_o`.
- R9: `faulting_o[i]` is the OR of `fault_o[i]`, `crc_err_o[i]`, `over_temp_o[i]` and `uv_alarm_o[i]`. In single-byte mode the CRC, overtemperature and undervoltage flags are all zero, so the fault line is the only diagnostic.
- R10: All result outputs change only together with a one-cycle `done_o`, which is raised two clock cycles after the last falling `sclk_o` edge. Between `done_o` pulses the results hold.
- R11: A chain length of 0 on `chips_i` is treated as 1, and a value above `MAX_CHIPS` is treated as `MAX_CHIPS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst request pulse |
| chips_i | input | $clog2(MAX_CHIPS+1) | Chain length N |
| mode16_i | input | 1 | 1: input byte plus status byte per chip; 0: input byte only |
| ign_uv_i | input | 1 | Ignore undervoltage flags and fault lines |
| fault_shared_i | input | 1 | 1: `fault_pin_i[0]` serves all chips |
| fault_pin_i | input | MAX_CHIPS | Fault line levels, active high |
| miso_i | input | 1 | Serial data from the chain |
| sclk_o | output | 1 | SPI clock, idle low |
| cs_n_o | output | 1 | Chip select, active low |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse, results updated |
| inputs_o | output | 8*MAX_CHIPS | Packed input values |
| crc_err_o | output | MAX_CHIPS | Per-chip CRC mismatch |
| over_temp_o | output | MAX_CHIPS | Per-chip overtemperature |
| uv_alarm_o | output | MAX_CHIPS | Per-chip undervoltage alarm |
| uv_warn_o | output | MAX_CHIPS | Per-chip undervoltage warning |
| fault_o | output | MAX_CHIPS | Per-chip fault line result |
| faulting_o | output | MAX_CHIPS | Per-chip untrusted-input flag |

## Verification
Two events can share a cycle: the `done_o` pulse that publishes one burst's results and the start request for the next burst. The bench raises every new request in the very cycle `done_o` is seen. It then checks that the request is accepted (`busy_o` rises), that `done_o` drops, and that the published bitmaps still equal the previous burst's expected values while the new frame is being shifted. A second overlap is a request issued in the middle of a burst with a different chain length and mode. It is judged by counting rising `sclk_o` edges against 8×N×W of the original settings and by checking the decoded flags against those settings.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SHIFT,
    ENG_CLOSE
  } eng_state_e;

  // 5-bit check value over one byte, generator x^5+x^4+x^2+1, aligned
  // to the top of an 8-bit register, zero start, high bit first.
  function automatic logic [4:0] crc5_of(input logic [7:0] d);
    logic [7:0] c;
    c = d;
    for (int b = 0; b < 8; b++) begin
      c = {c[6:0], 1'b0} ^ (c[7] ? 8'hA8 : 8'h00);
    end
    return c[7:3];
  endfunction

endpackage

// File: rtl/cdr_spi_engine.sv
module cdr_spi_engine
  import cdr_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int MAX_BYTES = 8,
  localparam int NB_W     = $clog2(MAX_BYTES + 1),
  localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic [NB_W-1:0] nbytes_i,
  input  logic            miso_i,
  output logic            sclk_o,
  output logic            cs_n_o,
  output logic            busy_o,
  output logic            byte_vld_o,
  output logic [7:0]      byte_o,
  output logic [NB_W-1:0] byte_idx_o,
  output logic            end_o
);

  eng_state_e      state_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]      bit_q;
  logic [NB_W-1:0] byte_cnt_q;
  logic [NB_W-1:0] nbytes_q;
  logic [7:0]      sh_q;
  logic            half_done;

  assign half_done = (div_q == DIV_W'(HALF_DIV - 1));
  assign busy_o    = (state_q != ENG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ENG_IDLE;
      div_q      <= '0;
      bit_q      <= '0;
      byte_cnt_q <= '0;
      nbytes_q   <= '0;
      sh_q       <= '0;
      sclk_o     <= 1'b0;
      cs_n_o     <= 1'b1;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_idx_o <= '0;
      end_o      <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      end_o      <= 1'b0;
      case (state_q)
        ENG_IDLE: begin
          if (go_i) begin
            state_q    <= ENG_SHIFT;
            cs_n_o     <= 1'b0;
            sclk_o     <= 1'b0;
            div_q      <= '0;
            bit_q      <= '0;
            byte_cnt_q <= '0;
            nbytes_q   <= nbytes_i;
          end
        end
        ENG_SHIFT: begin
          if (half_done) begin
            div_q <= '0;
            if (!sclk_o) begin
              sclk_o <= 1'b1;
              sh_q   <= {sh_q[6:0], miso_i};
            end else begin
              sclk_o <= 1'b0;
              bit_q  <= bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                byte_vld_o <= 1'b1;
                byte_o     <= sh_q;
                byte_idx_o <= byte_cnt_q;
                byte_cnt_q <= byte_cnt_q + NB_W'(1);
                if (byte_cnt_q == nbytes_q - NB_W'(1)) begin
                  state_q <= ENG_CLOSE;
                end
              end
            end
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        ENG_CLOSE: begin
          cs_n_o  <= 1'b1;
          end_o   <= 1'b1;
          state_q <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  // R1
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R1
  byte_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> (byte_idx_o < nbytes_q));

  // R1
  cs_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> $past(!sclk_o));

endmodule

// File: rtl/cdr_frame_store.sv
module cdr_frame_store #(
  parameter int MAX_CHIPS = 4,
  localparam int NB_W     = $clog2(2 * MAX_CHIPS + 1),
  localparam int IN_W     = 8 * MAX_CHIPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            mode16_i,
  input  logic            byte_vld_i,
  input  logic [7:0]      byte_i,
  input  logic [NB_W-1:0] byte_idx_i,
  output logic [IN_W-1:0] in_bytes_o,
  output logic [IN_W-1:0] st_bytes_o
);

  logic [NB_W-1:0] chip_sel;
  logic            is_status;

  assign chip_sel  = mode16_i ? (byte_idx_i >> 1) : byte_idx_i;
  assign is_status = mode16_i & byte_idx_i[0];

  for (genvar g = 0; g < MAX_CHIPS; g++) begin : g_chip
    logic hit;
    assign hit = byte_vld_i && (chip_sel == NB_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_bytes_o[8*g +: 8] <= '0;
        st_bytes_o[8*g +: 8] <= '0;
      end else if (clear_i) begin
        in_bytes_o[8*g +: 8] <= '0;
        st_bytes_o[8*g +: 8] <= '0;
      end else if (hit) begin
        if (is_status) st_bytes_o[8*g +: 8] <= byte_i;
        else           in_bytes_o[8*g +: 8] <= byte_i;
      end
    end
  end

  // R3
  status_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !mode16_i) |=> $stable(st_bytes_o));

endmodule

// File: rtl/cdr_chip_decode.sv
module cdr_chip_decode
  import cdr_pkg::*;
#(
  parameter int MAX_CHIPS = 4,
  localparam int IN_W     = 8 * MAX_CHIPS
) (
  input  logic [IN_W-1:0]      in_bytes_i,
  input  logic [IN_W-1:0]      st_bytes_i,
  input  logic [MAX_CHIPS-1:0] pins_i,
  input  logic [MAX_CHIPS-1:0] en_i,
  input  logic                 mode16_i,
  input  logic                 ign_uv_i,
  output logic [IN_W-1:0]      inputs_o,
  output logic [MAX_CHIPS-1:0] crc_o,
  output logic [MAX_CHIPS-1:0] ot_o,
  output logic [MAX_CHIPS-1:0] uva_o,
  output logic [MAX_CHIPS-1:0] uvw_o,
  output logic [MAX_CHIPS-1:0] flt_o,
  output logic [MAX_CHIPS-1:0] fing_o
);

  for (genvar g = 0; g < MAX_CHIPS; g++) begin : g_chip
    logic [7:0] in_b;
    logic [7:0] st_b;
    logic       stat_ok;
    logic       uv_ok;

    assign in_b    = in_bytes_i[8*g +: 8];
    assign st_b    = st_bytes_i[8*g +: 8];
    assign stat_ok = en_i[g] & mode16_i;
    assign uv_ok   = stat_ok & ~ign_uv_i;

    always_comb begin
      inputs_o[8*g +: 8] = en_i[g] ? in_b : 8'h00;
      crc_o[g]  = stat_ok & (st_b[7:3] != crc5_of(in_b));
      ot_o[g]   = stat_ok & st_b[1];
      uva_o[g]  = uv_ok & ~st_b[2];
      uvw_o[g]  = uv_ok & ~st_b[0];
      flt_o[g]  = en_i[g] & ~ign_uv_i & pins_i[g];
      fing_o[g] = flt_o[g] | crc_o[g] | ot_o[g] | uva_o[g];
    end
  end

endmodule

// File: rtl/chain_diag_reader.sv
module chain_diag_reader
  import cdr_pkg::*;
#(
  parameter int MAX_CHIPS = 4,
  parameter int HALF_DIV  = 2,
  localparam int CNT_W    = $clog2(MAX_CHIPS + 1),
  localparam int NB_W     = $clog2(2 * MAX_CHIPS + 1),
  localparam int IN_W     = 8 * MAX_CHIPS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     chips_i,
  input  logic                 mode16_i,
  input  logic                 ign_uv_i,
  input  logic                 fault_shared_i,
  input  logic [MAX_CHIPS-1:0] fault_pin_i,
  input  logic                 miso_i,
  output logic                 sclk_o,
  output logic                 cs_n_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [IN_W-1:0]      inputs_o,
  output logic [MAX_CHIPS-1:0] crc_err_o,
  output logic [MAX_CHIPS-1:0] over_temp_o,
  output logic [MAX_CHIPS-1:0] uv_alarm_o,
  output logic [MAX_CHIPS-1:0] uv_warn_o,
  output logic [MAX_CHIPS-1:0] fault_o,
  output logic [MAX_CHIPS-1:0] faulting_o
);

  logic                 go;
  logic [CNT_W-1:0]     n_eff;
  logic [NB_W-1:0]      nb_one;
  logic [NB_W-1:0]      nbytes;
  logic [MAX_CHIPS-1:0] mask_in;
  logic                 mode_q, ign_q, shr_q;
  logic [MAX_CHIPS-1:0] mask_q;
  logic                 byte_vld;
  logic [7:0]           byte_d;
  logic [NB_W-1:0]      byte_idx;
  logic                 eng_end;
  logic [IN_W-1:0]      in_bytes, st_bytes, d_inputs;
  logic [MAX_CHIPS-1:0] pins_eff;
  logic [MAX_CHIPS-1:0] d_crc, d_ot, d_uva, d_uvw, d_flt, d_fing;

  assign go = start_i & ~busy_o;

  always_comb begin
    if (chips_i == '0)                        n_eff = CNT_W'(1);
    else if (chips_i > CNT_W'(MAX_CHIPS))     n_eff = CNT_W'(MAX_CHIPS);
    else                                      n_eff = chips_i;
  end

  assign nb_one = NB_W'(n_eff);
  assign nbytes = mode16_i ? (nb_one << 1) : nb_one;

  always_comb begin
    for (int i = 0; i < MAX_CHIPS; i++) begin
      mask_in[i] = (i < int'(n_eff));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ign_q  <= 1'b0;
      shr_q  <= 1'b0;
      mask_q <= '0;
    end else if (go) begin
      mode_q <= mode16_i;
      ign_q  <= ign_uv_i;
      shr_q  <= fault_shared_i;
      mask_q <= mask_in;
    end
  end

  cdr_spi_engine #(
    .HALF_DIV  (HALF_DIV),
    .MAX_BYTES (2 * MAX_CHIPS)
  ) eng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go),
    .nbytes_i   (nbytes),
    .miso_i     (miso_i),
    .sclk_o     (sclk_o),
    .cs_n_o     (cs_n_o),
    .busy_o     (busy_o),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d),
    .byte_idx_o (byte_idx),
    .end_o      (eng_end)
  );

  cdr_frame_store #(
    .MAX_CHIPS (MAX_CHIPS)
  ) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (go),
    .mode16_i   (mode_q),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_d),
    .byte_idx_i (byte_idx),
    .in_bytes_o (in_bytes),
    .st_bytes_o (st_bytes)
  );

  assign pins_eff = shr_q ? {MAX_CHIPS{fault_pin_i[0]}} : fault_pin_i;

  cdr_chip_decode #(
    .MAX_CHIPS (MAX_CHIPS)
  ) dec_i (
    .in_bytes_i (in_bytes),
    .st_bytes_i (st_bytes),
    .pins_i     (pins_eff),
    .en_i       (mask_q),
    .mode16_i   (mode_q),
    .ign_uv_i   (ign_q),
    .inputs_o   (d_inputs),
    .crc_o      (d_crc),
    .ot_o       (d_ot),
    .uva_o      (d_uva),
    .uvw_o      (d_uvw),
    .flt_o      (d_flt),
    .fing_o     (d_fing)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      inputs_o    <= '0;
      crc_err_o   <= '0;
      over_temp_o <= '0;
      uv_alarm_o  <= '0;
      uv_warn_o   <= '0;
      fault_o     <= '0;
      faulting_o  <= '0;
    end else begin
      done_o <= eng_end;
      if (eng_end) begin
        inputs_o    <= d_inputs;
        crc_err_o   <= d_crc;
        over_temp_o <= d_ot;
        uv_alarm_o  <= d_uva;
        uv_warn_o   <= d_uvw;
        fault_o     <= d_flt;
        faulting_o  <= d_fing;
      end
    end
  end

  // R2
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(mode_q) && $stable(mask_q) && $stable(ign_q)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(faulting_o) && $stable(inputs_o) && $stable(fault_o)));

  // R7
  ignore_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ign_q) |-> (uv_alarm_o == '0 && uv_warn_o == '0 && fault_o == '0));

  // R9
  single_byte_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !mode_q) |-> (crc_err_o == '0 && over_temp_o == '0 && uv_alarm_o == '0));

  // R3
  absent_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((faulting_o & ~mask_q) == '0));

endmodule

// File: tb/chain_diag_reader_tb_top.sv
`timescale 1ns/1ps
module chain_diag_reader_tb_top;

  localparam int MAXC  = 4;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int IW    = 8 * MAXC;
  localparam int NBITS = 2 * IW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [CW-1:0]   chips_i = '0;
  logic            mode16_i = 1'b0;
  logic            ign_uv_i = 1'b0;
  logic            fault_shared_i = 1'b0;
  logic [MAXC-1:0] fault_pin_i = '0;
  logic            miso_i = 1'b0;
  logic            sclk_o, cs_n_o, busy_o, done_o;
  logic [IW-1:0]   inputs_o;
  logic [MAXC-1:0] crc_err_o, over_temp_o, uv_alarm_o, uv_warn_o, fault_o, faulting_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  chain_diag_reader #(.MAX_CHIPS(MAXC), .HALF_DIV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chips_i(chips_i),
    .mode16_i(mode16_i), .ign_uv_i(ign_uv_i), .fault_shared_i(fault_shared_i),
    .fault_pin_i(fault_pin_i), .miso_i(miso_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
    .busy_o(busy_o), .done_o(done_o), .inputs_o(inputs_o), .crc_err_o(crc_err_o),
    .over_temp_o(over_temp_o), .uv_alarm_o(uv_alarm_o), .uv_warn_o(uv_warn_o),
    .fault_o(fault_o), .faulting_o(faulting_o)
  );

  // serial slave model: mode 0, data changes after each falling clock
  logic sbits [0:NBITS-1];
  int   sidx = 0;
  int   rises = 0;

  always @(negedge cs_n_o) begin
    sidx   = 0;
    rises  = 0;
    miso_i = sbits[0];
  end
  always @(negedge sclk_o) begin
    if (!cs_n_o) begin
      sidx = sidx + 1;
      if (sidx < NBITS) miso_i = sbits[sidx];
    end
  end
  always @(posedge sclk_o) begin
    if (!cs_n_o) rises = rises + 1;
  end

  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [4:0] c = 5'h00;
    for (int b = 7; b >= 0; b--) begin
      logic fb = d[b] ^ c[4];
      c = {c[3:0], 1'b0} ^ (fb ? 5'h15 : 5'h00);
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-run stimulus and expectations
  logic [7:0]      in_b [MAXC];
  logic [7:0]      st_b [MAXC];
  logic [IW-1:0]   e_in, p_in;
  logic [MAXC-1:0] e_crc, e_ot, e_uva, e_uvw, e_flt, e_fing, p_fing;

  task automatic run(input int n, input bit m16, input bit ign, input bit shr,
                     input logic [MAXC-1:0] pins);
    int neff, pos, cyc;
    bit got;
    neff = (n == 0) ? 1 : ((n > MAXC) ? MAXC : n);
    pos = 0;
    for (int k = 0; k < NBITS; k++) sbits[k] = 1'b0;
    for (int i = 0; i < neff; i++) begin
      for (int b = 7; b >= 0; b--) begin sbits[pos] = in_b[i][b]; pos++; end
      if (m16) for (int b = 7; b >= 0; b--) begin sbits[pos] = st_b[i][b]; pos++; end
    end
    p_in = e_in; p_fing = e_fing;
    e_in = '0; e_crc = '0; e_ot = '0; e_uva = '0; e_uvw = '0; e_flt = '0;
    for (int i = 0; i < neff; i++) begin
      logic pin;
      e_in[8*i +: 8] = in_b[i];
      if (m16) begin
        e_crc[i] = (st_b[i][7:3] != ref_crc(in_b[i]));
        e_ot[i]  = st_b[i][1];
        e_uva[i] = !ign && !st_b[i][2];
        e_uvw[i] = !ign && !st_b[i][0];
      end
      pin = shr ? pins[0] : pins[i];
      e_flt[i] = !ign && pin;
    end
    e_fing = e_flt | e_crc | e_ot | e_uva;

    chips_i = CW'(n); mode16_i = m16; ign_uv_i = ign;
    fault_shared_i = shr; fault_pin_i = pins;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // request raised in the done cycle of the previous run is accepted
    check("R2 busy after accept", 64'(busy_o), 64'd1);
    check("R10 done low after pulse", 64'(done_o), 64'd0);
    check("R10 inputs held", 64'(inputs_o), 64'(p_in));
    check("R10 faulting held", 64'(faulting_o), 64'(p_fing));

    got = 1'b0;
    cyc = 0;
    while (!got && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 10) begin
        start_i = 1'b1;
        chips_i = CW'($urandom % 8);
        mode16_i = ~m16;
        ign_uv_i = ~ign;
      end else if (cyc == 11) begin
        start_i = 1'b0;
      end
      if (done_o) got = 1'b1;
    end
    if (!got) begin
      tests++; fails++;
      $display("FAIL R10 no done pulse actual=0 expected=1");
    end else begin
      check("R1/R2 sclk rises", 64'(rises), 64'(8 * neff * (m16 ? 2 : 1)));
      check("R1 cs high at done", 64'(cs_n_o), 64'd1);
      check("R3/R11 inputs", 64'(inputs_o), 64'(e_in));
      check("R4 crc", 64'(crc_err_o), 64'(e_crc));
      check("R5 overtemp", 64'(over_temp_o), 64'(e_ot));
      check(ign ? "R7 uv alarm" : "R6 uv alarm", 64'(uv_alarm_o), 64'(e_uva));
      check(ign ? "R7 uv warn" : "R6 uv warn", 64'(uv_warn_o), 64'(e_uvw));
      check(ign ? "R7 fault" : "R8 fault", 64'(fault_o), 64'(e_flt));
      check("R9 faulting", 64'(faulting_o), 64'(e_fing));
    end
  endtask

  function automatic logic [7:0] good_status(input logic [7:0] d);
    return {ref_crc(d), 3'b101};
  endfunction

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    e_in = '0; e_fing = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset cs", 64'(cs_n_o), 64'd1);
    check("R1 reset sclk", 64'(sclk_o), 64'd0);
    check("R10 reset done", 64'(done_o), 64'd0);
    check("R10 reset inputs", 64'(inputs_o), 64'd0);
    check("R10 reset faulting", 64'(faulting_o), 64'd0);

    // full chain, status frames, all healthy
    for (int i = 0; i < MAXC; i++) begin
      in_b[i] = 8'(8'hA5 + 8'(i * 17)); st_b[i] = good_status(in_b[i]);
    end
    run(MAXC, 1'b1, 1'b0, 1'b0, '0);
    // single chip, input-only frames, fault line high (R9)
    in_b[0] = 8'h3C;
    run(1, 1'b0, 1'b0, 1'b0, 4'b0001);
    // CRC mismatch on chip 1, overtemp on chip 2, undervoltage on chip 0
    for (int i = 0; i < MAXC; i++) begin
      in_b[i] = 8'(8'h10 * i + 8'h07); st_b[i] = good_status(in_b[i]);
    end
    st_b[1][3] = ~st_b[1][3];
    st_b[2][1] = 1'b1;
    st_b[0][2] = 1'b0; st_b[0][0] = 1'b0;
    run(3, 1'b1, 1'b0, 1'b0, '0);
    // same data with undervoltage ignored and fault lines asserted (R7)
    run(3, 1'b1, 1'b1, 1'b0, 4'b1111);
    // shared fault line drives all chips (R8), length 0 clamps to 1 (R11)
    run(MAXC, 1'b1, 1'b0, 1'b1, 4'b0001);
    run(0, 1'b1, 1'b0, 1'b0, '0);
    run(7, 1'b0, 1'b0, 1'b0, 4'b0100);

    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < MAXC; i++) begin
        logic [4:0] cf;
        logic [2:0] lo;
        in_b[i] = 8'($urandom);
        cf = ($urandom % 5 == 0) ? 5'($urandom) : ref_crc(in_b[i]);
        lo = ($urandom % 3 == 0) ? 3'($urandom) : 3'b101;
        st_b[i] = {cf, lo};
      end
      run(int'($urandom % 8), 1'($urandom), ($urandom % 4) == 0, 1'($urandom),
          ($urandom % 3 == 0) ? MAXC'($urandom) : '0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule